// File: doc/BRIEF.md
# DMA Stream Interrupt Flag Controller

This block gathers single-cycle event pulses from four DMA streams and holds them as sticky status flags. Each stream reports five kinds of event: half of the transfer done, transfer finished, transfer error, FIFO error (overrun, underrun or level fault) and direct-mode error. A per-flag enable input masks each flag onto one registered interrupt line per stream.

Software reads all twenty flags from one 32-bit status word and clears them through a second, write-one-to-clear word. Every access is a full 32-bit word. Each stream's flags sit in a six-bit group with one unused bit. Two groups share each 16-bit half of the word, and the top four bits of each half are unused. If a hardware event and a software clear reach the same flag in the same cycle, the event wins, so no event is lost.

Top module: `dsif_ctrl`

## Requirements
- R1: After reset the status word reads 0x00000000 and every interrupt output is 0.
- R2: A pulse on an event input sets exactly one status bit, at position base+offset. The base is 0 for stream 0, 6 for stream 1, 16 for stream 2 and 22 for stream 3. The offset is 0 for FIFO error, 2 for direct-mode error, 3 for transfer error, 4 for half transfer and 5 for transfer complete. The bit is readable at the next bus read after the clock edge that sampled the pulse.
- R3: A flag stays set when no clear is written, and a further pulse on a flag that is already set leaves it set.
- R4: Writing a word to byte offset 0x08 clears every flag whose bit position holds a 1. Bits that hold 0 leave their flags unchanged.
- R5: Writing any value to the status word at offset 0x00 changes no flag.
- R6: When an event pulse and a clear write for the same flag land in the same cycle, the flag ends up set.
- R7: Unused status bits (31:28, 15:12 and bit 1 of each group) always read 0. A read of the clear word at 0x08 returns 0.
- R8: A stream's interrupt is the OR of its flags, each ANDed with its matching enable. The output is registered, so it changes one clock after the flag or enable changes.
- R9: Raising an enable while its flag is already set asserts the interrupt one clock later, with no new event needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on the current access) |
| evt_fifo | input | 4 | FIFO error pulse, one bit per stream |
| evt_dme | input | 4 | Direct-mode error pulse, one bit per stream |
| evt_terr | input | 4 | Transfer error pulse, one bit per stream |
| evt_half | input | 4 | Half-transfer pulse, one bit per stream |
| evt_done | input | 4 | Transfer complete pulse, one bit per stream |
| ien_fifo | input | 4 | FIFO error interrupt enables |
| ien_dme | input | 4 | Direct-mode error interrupt enables |
| ien_terr | input | 4 | Transfer error interrupt enables |
| ien_half | input | 4 | Half-transfer interrupt enables |
| ien_done | input | 4 | Transfer complete interrupt enables |
| irq | output | 4 | Registered interrupt, one per stream |

## Verification
The bench drives each of the twenty events in turn and checks that it lands at the one expected bit and nowhere else. A swapped group base or offset would show up as a stray or missing bit. It makes an event and a clear meet on the same flag in the same cycle, and a design where the clear wins would read the flag back as 0. It raises an enable on a flag that is already set and checks the interrupt in both the cycle before the register edge and the cycle after it. A combinational output or a design that waits for a new edge would fail one of these two checks. Writes to the status word and writes of zero to the clear word must leave the flags intact, which catches a decoder that clears on any write.

// File: rtl/dsif_pkg.sv
package dsif_pkg;
  localparam int NUM_STREAMS = 4;
  localparam int NUM_KINDS   = 5;
  localparam int DATA_W      = 32;
  localparam int GROUP_W     = 6;
  localparam int BANK_STRIDE = 16;
  localparam int FLAG_N      = NUM_STREAMS * NUM_KINDS;

  // event kind indices inside a stream's flag vector
  localparam int K_FIFO = 0;
  localparam int K_DME  = 1;
  localparam int K_TERR = 2;
  localparam int K_HALF = 3;
  localparam int K_DONE = 4;

  // bit offset of a kind within its six-bit group (bit 1 left unused)
  function automatic int kind_bit(input int k);
    case (k)
      K_FIFO:  return 0;
      K_DME:   return 2;
      K_TERR:  return 3;
      K_HALF:  return 4;
      default: return 5;
    endcase
  endfunction

  // two groups per 16-bit bank
  function automatic int group_base(input int s);
    return (s / 2) * BANK_STRIDE + (s % 2) * GROUP_W;
  endfunction

  function automatic int flag_pos(input int s, input int k);
    return group_base(s) + kind_bit(k);
  endfunction

  function automatic logic [DATA_W-1:0] used_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_STREAMS; s++)
      for (int k = 0; k < NUM_KINDS; k++)
        m[flag_pos(s, k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dsif_stream_flags.sv
module dsif_stream_flags
  import dsif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_KINDS-1:0] set_i,
  input  logic [NUM_KINDS-1:0] clr_i,
  output logic [NUM_KINDS-1:0] flags_o
);
  logic [NUM_KINDS-1:0] flags_q;
  logic [NUM_KINDS-1:0] flags_d;

  // set has priority over clear so that no event is lost
  always_comb flags_d = (flags_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R6: every pulsed flag is set after the edge, whatever the clear said
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  // R4: a cleared flag without a coincident set drops
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

  // R3: set flags without a clear stay set
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & $past(flags_o & ~clr_i)) == $past(flags_o & ~clr_i)));

  // R2: a flag rises only when its own event pulsed
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/dsif_irq_gen.sv
module dsif_irq_gen
  import dsif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLAG_N-1:0]  flags_i,
  input  logic [FLAG_N-1:0]  en_i,
  output logic [NUM_STREAMS-1:0] irq_o
);
  logic [NUM_STREAMS-1:0] pend_w;
  logic [NUM_STREAMS-1:0] irq_q;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_pend
    assign pend_w[s] = |(flags_i[s*NUM_KINDS +: NUM_KINDS] &
                         en_i[s*NUM_KINDS +: NUM_KINDS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= pend_w;
  end

  assign irq_o = irq_q;

  // R8: the output is the masked OR one clock late
  p_irq_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(pend_w)));

  // R9: an enabled flag that is set always leads to an interrupt
  p_irq_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & en_i) != '0) |=> (irq_o != '0));
endmodule

// File: rtl/dsif_regif.sv
module dsif_regif
  import dsif_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STATUS_OFS = 0,
  parameter int CLEAR_OFS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [FLAG_N-1:0] flags_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FLAG_N-1:0] clr_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(CLEAR_OFS);
  localparam logic [DATA_W-1:0] USED     = used_mask();

  logic              rd_status_w;
  logic              wr_clear_w;
  logic [DATA_W-1:0] status_w;
  logic              unused_wdata;

  assign rd_status_w = bus_sel && !bus_wr && (bus_addr == A_STATUS);
  assign wr_clear_w  = bus_sel &&  bus_wr && (bus_addr == A_CLEAR);

  // scatter flags into the packed word
  always_comb begin
    status_w = '0;
    for (int s = 0; s < NUM_STREAMS; s++)
      for (int k = 0; k < NUM_KINDS; k++)
        status_w[flag_pos(s, k)] = flags_i[s*NUM_KINDS + k];
  end

  assign rdata_o = rd_status_w ? status_w : '0;

  // gather clear requests from the written word
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_s
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_k
      localparam int POS = flag_pos(s, k);
      assign clr_o[s*NUM_KINDS + k] = wr_clear_w & bus_wdata[POS];
    end
  end

  assign unused_wdata = ^(bus_wdata & ~USED);

  // R7: unused bits of any read are zero
  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata_o & ~USED) == '0));

  // R7: the clear word reads back as zero
  p_clear_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == A_CLEAR) |-> (rdata_o == '0));

  // R5: only a write to the clear word can request a clear
  p_no_clear_else_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == A_CLEAR) |-> (clr_o == '0));
endmodule

// File: rtl/dsif_ctrl.sv
module dsif_ctrl
  import dsif_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STATUS_OFS = 0,
  parameter int CLEAR_OFS  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NUM_STREAMS-1:0] evt_fifo,
  input  logic [NUM_STREAMS-1:0] evt_dme,
  input  logic [NUM_STREAMS-1:0] evt_terr,
  input  logic [NUM_STREAMS-1:0] evt_half,
  input  logic [NUM_STREAMS-1:0] evt_done,
  input  logic [NUM_STREAMS-1:0] ien_fifo,
  input  logic [NUM_STREAMS-1:0] ien_dme,
  input  logic [NUM_STREAMS-1:0] ien_terr,
  input  logic [NUM_STREAMS-1:0] ien_half,
  input  logic [NUM_STREAMS-1:0] ien_done,
  output logic [NUM_STREAMS-1:0] irq
);
  logic [FLAG_N-1:0] set_w;
  logic [FLAG_N-1:0] en_w;
  logic [FLAG_N-1:0] clr_w;
  logic [FLAG_N-1:0] flags_w;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    assign set_w[s*NUM_KINDS + K_FIFO] = evt_fifo[s];
    assign set_w[s*NUM_KINDS + K_DME ] = evt_dme[s];
    assign set_w[s*NUM_KINDS + K_TERR] = evt_terr[s];
    assign set_w[s*NUM_KINDS + K_HALF] = evt_half[s];
    assign set_w[s*NUM_KINDS + K_DONE] = evt_done[s];
    assign en_w[s*NUM_KINDS + K_FIFO]  = ien_fifo[s];
    assign en_w[s*NUM_KINDS + K_DME ]  = ien_dme[s];
    assign en_w[s*NUM_KINDS + K_TERR]  = ien_terr[s];
    assign en_w[s*NUM_KINDS + K_HALF]  = ien_half[s];
    assign en_w[s*NUM_KINDS + K_DONE]  = ien_done[s];

    dsif_stream_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_w[s*NUM_KINDS +: NUM_KINDS]),
      .clr_i   (clr_w[s*NUM_KINDS +: NUM_KINDS]),
      .flags_o (flags_w[s*NUM_KINDS +: NUM_KINDS])
    );
  end

  dsif_regif #(
    .ADDR_W     (ADDR_W),
    .STATUS_OFS (STATUS_OFS),
    .CLEAR_OFS  (CLEAR_OFS)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flags_i   (flags_w),
    .rdata_o   (bus_rdata),
    .clr_o     (clr_w)
  );

  dsif_irq_gen u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags_w),
    .en_i    (en_w),
    .irq_o   (irq)
  );

  // R1: outputs stay quiet while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (irq == '0));
endmodule

// File: tb/dsif_ctrl_tb.sv
module dsif_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  evt_fifo = '0, evt_dme = '0, evt_terr = '0, evt_half = '0, evt_done = '0;
  logic [3:0]  ien_fifo = '0, ien_dme = '0, ien_terr = '0, ien_half = '0, ien_done = '0;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dsif_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_fifo(evt_fifo), .evt_dme(evt_dme), .evt_terr(evt_terr),
    .evt_half(evt_half), .evt_done(evt_done),
    .ien_fifo(ien_fifo), .ien_dme(ien_dme), .ien_terr(ien_terr),
    .ien_half(ien_half), .ien_done(ien_done), .irq(irq)
  );

  // expected bit position, written as a lookup rather than arithmetic
  function automatic int exp_pos(input int s, input int k);
    int base, off;
    case (s) 0: base = 0; 1: base = 6; 2: base = 16; default: base = 22; endcase
    case (k) 0: off = 0; 1: off = 2; 2: off = 3; 3: off = 4; default: off = 5; endcase
    return base + off;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic drive_evt(input int s, input int k, input logic v);
    case (k)
      0: evt_fifo[s] = v;
      1: evt_dme[s]  = v;
      2: evt_terr[s] = v;
      3: evt_half[s] = v;
      default: evt_done[s] = v;
    endcase
  endtask

  task automatic pulse(input int s, input int k);
    drive_evt(s, k, 1'b1);
    @(negedge clk);
    drive_evt(s, k, 1'b0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d);
    check("R1 status after reset", d, 32'h0);
    check("R1 irq after reset", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 5; k++) begin
        pulse(s, k);
        rd(4'h0, d);
        check("R2 event bit position", d, 32'h1 << exp_pos(s, k));
        wr(4'h8, 32'h1 << exp_pos(s, k));
        rd(4'h0, d);
        check("R4 clear by writing one", d, 32'h0);
      end
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    pulse(1, 4);
    repeat (5) @(negedge clk);
    rd(4'h0, d);
    check("R3 flag held while idle", d, 32'h1 << exp_pos(1, 4));
    pulse(1, 4);
    rd(4'h0, d);
    check("R3 repeat pulse keeps flag", d, 32'h1 << exp_pos(1, 4));
    wr(4'h8, 32'h0);
    rd(4'h0, d);
    check("R4 writing zero clears nothing", d, 32'h1 << exp_pos(1, 4));
    wr(4'h8, ~(32'h1 << exp_pos(1, 4)));
    rd(4'h0, d);
    check("R4 other ones leave flag", d, 32'h1 << exp_pos(1, 4));
    wr(4'h8, 32'hFFFF_FFFF);
  endtask

  task automatic t_status_write;
    logic [31:0] d, e;
    pulse(2, 2);
    pulse(3, 0);
    e = (32'h1 << exp_pos(2, 2)) | (32'h1 << exp_pos(3, 0));
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d);
    check("R5 status write ignored", d, e);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h0, d);
    check("R4 clear all", d, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    pulse(0, 3);
    pulse(0, 1);
    drive_evt(0, 3, 1'b1);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h8;
    bus_wdata = (32'h1 << exp_pos(0, 3)) | (32'h1 << exp_pos(0, 1));
    @(negedge clk);
    drive_evt(0, 3, 1'b0);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    rd(4'h0, d);
    check("R6 set beats clear in same cycle", d, 32'h1 << exp_pos(0, 3));
    wr(4'h8, 32'hFFFF_FFFF);
  endtask

  task automatic t_reserved;
    logic [31:0] d, e;
    e = '0;
    evt_fifo = 4'hF; evt_dme = 4'hF; evt_terr = 4'hF; evt_half = 4'hF; evt_done = 4'hF;
    @(negedge clk);
    evt_fifo = '0; evt_dme = '0; evt_terr = '0; evt_half = '0; evt_done = '0;
    for (int s = 0; s < 4; s++) for (int k = 0; k < 5; k++) e[exp_pos(s, k)] = 1'b1;
    rd(4'h0, d);
    check("R7 all flags, unused bits zero", d, e);
    check("R7 full pattern constant", d, 32'h0F7D_0F7D);
    rd(4'h8, d);
    check("R7 clear word reads zero", d, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h0, d);
    check("R4 all cleared", d, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    pulse(2, 3);
    @(negedge clk);
    check("R8 no irq with enables off", {28'h0, irq}, 32'h0);
    ien_done[2] = 1'b1;
    @(negedge clk);
    check("R8 mismatched enable masks flag", {28'h0, irq}, 32'h0);
    ien_half[2] = 1'b1;
    #1 check("R8 irq waits for clock edge", {28'h0, irq}, 32'h0);
    @(negedge clk);
    check("R9 enable on set flag raises irq", {28'h0, irq}, 32'h4);
    wr(4'h8, 32'h1 << exp_pos(2, 3));
    check("R8 irq lags clear by one clock", {28'h0, irq}, 32'h4);
    @(negedge clk);
    check("R8 irq drops after clear", {28'h0, irq}, 32'h0);
    pulse(2, 4);
    check("R8 irq one clock after event", {28'h0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq after event latency", {28'h0, irq}, 32'h4);
    ien_done[2] = 1'b0; ien_half[2] = 1'b0;
    wr(4'h8, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 irq idle at end", {28'h0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_sticky();
    t_status_write();
    t_collide();
    t_reserved();
    t_irq();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule